// File: doc/BRIEF.md
# Base-Proximity Decimal Multiplier

This block multiplies two 8-bit unsigned operands by working against a decimal base that the caller picks to sit close to both operands. Each operand is turned into decimal digits, and its signed distance from the base is taken from those digits. The product of the two distances forms the low part of the answer. The high part is the first operand plus the second distance, scaled up to the base by multiplying by ten one step at a time and then halving where the base calls for it. The two parts are then added, so a negative low part borrows from the high part. The sum is turned into five packed decimal digits.

A caller presents the operands and a base select, and pulses `start` for one cycle while the block is idle. Some cycles later `done` is high for a single cycle, and at that cycle `product_bcd` carries the new result. The result holds until the next `done`. There is no back-pressure on the result: `done` is a one-cycle strobe and the caller must take the value then or read the held register later. A `start` that arrives while the block is busy is dropped. The caller waits for `done` before it offers the next operation.

Top module: `basemul_top`

## Requirements
- R1: A `start` pulse seen while idle captures `op_a`, `op_b` and `base_sel`. `base_sel` selects the working base: 0 gives 50, 1 gives 60, 2 gives 200 and 3 gives 100.
- R2: At `done`, `product_bcd` equals `op_a * op_b` as five packed decimal digits, with the units digit in bits 3:0 and the ten-thousands digit in bits 19:16. This holds for every operand pair and every base.
- R3: The result is exact when the two operands fall on opposite sides of the base, so that the low part is negative and must borrow from the high part.
- R4: `done` is high for exactly one cycle for each accepted `start`. `product_bcd` changes only at that cycle and holds its value at all other times.
- R5: A `start` raised while a computation is in progress has no effect. It produces no extra `done`, and the result comes from the operands captured first.
- R6: After reset, `done` is 0 and `product_bcd` is 0.
- R7: Every 4-bit digit of `product_bcd` is 9 or less whenever `done` is high.
- R8: For the same operand pair, all four base selections give the same `product_bcd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a multiply |
| op_a | input | 8 | First unsigned operand |
| op_b | input | 8 | Second unsigned operand |
| base_sel | input | 2 | Working base choice (0:50, 1:60, 2:200, 3:100) |
| done | output | 1 | One-cycle strobe: result valid |
| product_bcd | output | 20 | Product as five packed decimal digits |

## Verification
For each of the four bases, every value of the first operand is paired with a spread of second operands. This shows that the deviation method is exact far from the base as well as near it, and that the base select changes only the route to the answer, not the answer itself. A dense square around each base covers the products of two positive deviations, two negative deviations, and deviations of mixed sign. The mixed-sign case separates a correct borrow of the negative low part from a broken one. Targeted runs cover the zero and maximum operands, where a digit carries all the way to the top, and a second `start` raised mid-computation, which separates an ignored request from one that corrupts the captured operands.

// File: rtl/bm_pkg.sv
`timescale 1ns/1ps
package bm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_PART, ST_TEN, ST_DIV, ST_SUM, ST_OUT
  } bm_state_t;

  // number of decimal digits needed for the largest w-bit unsigned value
  function automatic int dec_digits(int w);
    longint m;
    int n;
    m = (longint'(1) << w) - 1;
    n = 0;
    while (m > 0) begin
      n++;
      m = m / 10;
    end
    return (n == 0) ? 1 : n;
  endfunction

  // working base W = (mult * 10^pow) >> shift
  function automatic logic [7:0] base_value(logic [1:0] s);
    case (s)
      2'd0:    return 8'd50;
      2'd1:    return 8'd60;
      2'd2:    return 8'd200;
      default: return 8'd100;
    endcase
  endfunction

  function automatic logic [3:0] base_mult(logic [1:0] s);
    case (s)
      2'd1:    return 4'd6;
      2'd2:    return 4'd2;
      default: return 4'd1;
    endcase
  endfunction

  function automatic logic [1:0] base_pow(logic [1:0] s);
    return (s == 2'd1) ? 2'd1 : 2'd2;
  endfunction

  function automatic logic base_shift(logic [1:0] s);
    return (s == 2'd0);
  endfunction

endpackage

// File: rtl/bm_bin2bcd.sv
`timescale 1ns/1ps
module bm_bin2bcd #(
  parameter int IN_W = 8,
  parameter int DIG  = 3
) (
  input  logic [IN_W-1:0]  bin,
  output logic [4*DIG-1:0] bcd
);
  localparam int SH_W = IN_W + 4*DIG;

  logic [SH_W-1:0] sh;

  // add-3-then-shift conversion, fully unrolled
  always_comb begin
    sh = '0;
    sh[IN_W-1:0] = bin;
    for (int i = 0; i < IN_W; i++) begin
      for (int d = 0; d < DIG; d++) begin
        if (sh[IN_W+4*d +: 4] > 4'd4)
          sh[IN_W+4*d +: 4] = sh[IN_W+4*d +: 4] + 4'd3;
      end
      sh = sh << 1;
    end
    bcd = sh[IN_W +: 4*DIG];
  end
endmodule

// File: rtl/bm_dev.sv
`timescale 1ns/1ps
module bm_dev #(
  parameter int OP_W = 8,
  parameter int DIG  = 3
) (
  input  logic [4*DIG-1:0]        bcd,
  input  logic [OP_W-1:0]         base,
  output logic signed [OP_W:0]    dev
);
  localparam int VW = 4*DIG;

  logic [VW-1:0] val;

  // decimal digits back to a magnitude, then signed distance from base
  always_comb begin
    val = '0;
    for (int d = DIG-1; d >= 0; d--)
      val = VW'(val * VW'(10)) + VW'(bcd[4*d +: 4]);
    dev = signed'({1'b0, val[OP_W-1:0]}) - signed'({1'b0, base});
  end
endmodule

// File: rtl/basemul_top.sv
`timescale 1ns/1ps
module basemul_top
  import bm_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start,
  input  logic [OP_W-1:0]                     op_a,
  input  logic [OP_W-1:0]                     op_b,
  input  logic [1:0]                          base_sel,
  output logic                                done,
  output logic [4*dec_digits(2*OP_W)-1:0]     product_bcd
);
  localparam int OP_DIG  = dec_digits(OP_W);
  localparam int RES_W   = 2*OP_W;
  localparam int RES_DIG = dec_digits(RES_W);
  localparam int DEV_W   = OP_W + 1;
  localparam int LHS_W   = OP_W + 2;
  localparam int ACC_W   = 2*OP_W + 4;
  localparam logic signed [ACC_W-1:0] TEN_C = ACC_W'(10);

  bm_state_t st;
  logic      busy;

  logic [1:0][OP_W-1:0]       ops_q;
  logic [1:0]                 sel_q;
  logic [OP_W-1:0]            a_q, b_q;
  logic [OP_W-1:0]            base_w;
  logic [1:0][4*OP_DIG-1:0]   ops_bcd;
  logic signed [DEV_W-1:0]    dev     [2];
  logic signed [DEV_W-1:0]    dev_q   [2];
  logic signed [LHS_W-1:0]    lhs;
  logic signed [ACC_W-1:0]    lhs_x, mult_x, dev_a_x, dev_b_x;
  logic signed [ACC_W-1:0]    acc, rhs, total;
  logic [1:0]                 cnt;
  logic [RES_W-1:0]           sum_q;
  logic [4*RES_DIG-1:0]       res_bcd;

  assign a_q    = ops_q[0];
  assign b_q    = ops_q[1];
  assign busy   = (st != ST_IDLE);
  assign base_w = OP_W'(base_value(sel_q));

  // per operand: decimal conversion and deviation from the base
  for (genvar i = 0; i < 2; i++) begin : g_op
    bm_bin2bcd #(.IN_W(OP_W), .DIG(OP_DIG)) u_cvt (
      .bin (ops_q[i]),
      .bcd (ops_bcd[i])
    );
    bm_dev #(.OP_W(OP_W), .DIG(OP_DIG)) u_dev (
      .bcd  (ops_bcd[i]),
      .base (base_w),
      .dev  (dev[i])
    );
  end

  // high part: A + (B - W); operands for the scaled and low products
  always_comb begin
    lhs     = LHS_W'({2'b00, a_q}) + LHS_W'({dev_q[1][DEV_W-1], dev_q[1]});
    lhs_x   = {{(ACC_W-LHS_W){lhs[LHS_W-1]}}, lhs};
    mult_x  = ACC_W'(base_mult(sel_q));
    dev_a_x = {{(ACC_W-DEV_W){dev_q[0][DEV_W-1]}}, dev_q[0]};
    dev_b_x = {{(ACC_W-DEV_W){dev_q[1][DEV_W-1]}}, dev_q[1]};
    total   = acc + rhs;
  end

  bm_bin2bcd #(.IN_W(RES_W), .DIG(RES_DIG)) u_res_cvt (
    .bin (sum_q),
    .bcd (res_bcd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      done        <= 1'b0;
      product_bcd <= '0;
      ops_q       <= '0;
      sel_q       <= '0;
      dev_q[0]    <= '0;
      dev_q[1]    <= '0;
      acc         <= '0;
      rhs         <= '0;
      cnt         <= '0;
      sum_q       <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          ops_q[0] <= op_a;
          ops_q[1] <= op_b;
          sel_q    <= base_sel;
          st       <= ST_DEV;
        end
        ST_DEV: begin
          dev_q[0] <= dev[0];
          dev_q[1] <= dev[1];
          st       <= ST_PART;
        end
        ST_PART: begin
          rhs <= dev_a_x * dev_b_x;
          acc <= lhs_x * mult_x;
          cnt <= base_pow(sel_q);
          st  <= ST_TEN;
        end
        ST_TEN: begin
          acc <= acc * TEN_C;
          cnt <= cnt - 2'd1;
          if (cnt == 2'd1) st <= ST_DIV;
        end
        ST_DIV: begin
          acc <= acc >>> base_shift(sel_q);
          st  <= ST_SUM;
        end
        ST_SUM: begin
          sum_q <= total[RES_W-1:0];
          st    <= ST_OUT;
        end
        ST_OUT: begin
          product_bcd <= res_bcd;
          done        <= 1'b1;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bm_chk.sv
`timescale 1ns/1ps
module bm_chk #(
  parameter int OP_W = 8,
  parameter int DIG  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic [4*DIG-1:0]  product_bcd,
  input logic [OP_W-1:0]   a_q,
  input logic [OP_W-1:0]   b_q,
  input logic [1:0]        sel_q
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product_bcd));

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q) && $stable(sel_q)));

  for (genvar d = 0; d < DIG; d++) begin : g_dig
    assert_bcd_digit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (product_bcd[4*d +: 4] <= 4'd9));
  end
endmodule

bind basemul_top bm_chk #(.OP_W(OP_W), .DIG(RES_DIG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .busy        (busy),
  .product_bcd (product_bcd),
  .a_q         (a_q),
  .b_q         (b_q),
  .sel_q       (sel_q)
);

// File: tb/sim_basemul_top.sv
`timescale 1ns/1ps
module sim_basemul_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [1:0]  base_sel = '0;
  logic        done;
  logic [19:0] product_bcd;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  basemul_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .base_sel(base_sel), .done(done), .product_bcd(product_bcd)
  );

  function automatic logic [19:0] to_bcd(int v);
    logic [19:0] r;
    int x;
    x = v;
    for (int d = 0; d < 5; d++) begin
      r[4*d +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  function automatic int base_of(logic [1:0] s);
    case (s)
      2'd0: return 50;
      2'd1: return 60;
      2'd2: return 200;
      default: return 100;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [19:0] act,
                       input logic [19:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operation; returns the result seen at done
  task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                        input logic [1:0] s, output logic [19:0] r,
                        output bit seen);
    @(negedge clk);
    op_a = a; op_b = b; base_sel = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    r = '0;
    for (int k = 0; k < 40 && !seen; k++) begin
      if (done) begin
        seen = 1'b1;
        r = product_bcd;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic op_check(input logic [7:0] a, input logic [7:0] b,
                          input logic [1:0] s);
    logic [19:0] r, e;
    bit seen;
    int w;
    string tag;
    run_op(a, b, s, r, seen);
    e = to_bcd(int'(a) * int'(b));
    w = base_of(s);
    tag = ((int'(a) - w) * (int'(b) - w) < 0) ? "R3 borrow" : "R2 product";
    check(seen && r == e, tag, r, e);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [19:0] r, r0, e;
    bit seen;
    int dones;

    repeat (3) @(negedge clk);
    // R6: reset state
    check(done == 1'b0, "R6 done at reset", {19'd0, done}, 20'd0);
    check(product_bcd == 20'd0, "R6 product at reset", product_bcd, 20'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(product_bcd == 20'd0, "R6 product after release", product_bcd, 20'd0);

    // R2/R7: extremes, full carry to the top digit
    op_check(8'd255, 8'd255, 2'd2);
    op_check(8'd0, 8'd0, 2'd0);
    op_check(8'd0, 8'd255, 2'd1);
    op_check(8'd1, 8'd1, 2'd3);

    // R3: opposite sides of the base
    op_check(8'd47, 8'd53, 2'd0);
    op_check(8'd195, 8'd207, 2'd2);
    op_check(8'd65, 8'd58, 2'd1);

    // R4: single-cycle done and held result
    run_op(8'd48, 8'd52, 2'd0, r, seen);
    @(negedge clk);
    check(done == 1'b0, "R4 done one cycle", {19'd0, done}, 20'd0);
    repeat (4) @(negedge clk);
    check(product_bcd == to_bcd(2496), "R4 result held", product_bcd, to_bcd(2496));

    // R5: start while busy is dropped
    @(negedge clk);
    op_a = 8'd47; op_b = 8'd52; base_sel = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op_a = 8'd255; op_b = 8'd255; base_sel = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    r = '0;
    for (int k = 0; k < 30; k++) begin
      if (done) begin
        dones++;
        r = product_bcd;
      end
      @(negedge clk);
    end
    check(dones == 1, "R5 single done", 20'(dones), 20'd1);
    check(r == to_bcd(2444), "R5 first operands kept", r, to_bcd(2444));

    // R1/R8: all four bases give the same product
    run_op(8'd123, 8'd77, 2'd0, r0, seen);
    e = to_bcd(123 * 77);
    check(seen && r0 == e, "R1 base 50", r0, e);
    for (int s = 1; s < 4; s++) begin
      run_op(8'd123, 8'd77, 2'(s), r, seen);
      check(seen && r == r0, "R8 base independence", r, r0);
    end

    // near-base squares for every base (R1, R3)
    for (int s = 0; s < 4; s++) begin
      for (int da = -6; da <= 6; da++) begin
        for (int db = -6; db <= 6; db++) begin
          op_check(8'(base_of(2'(s)) + da), 8'(base_of(2'(s)) + db), 2'(s));
        end
      end
    end

    // sweep: every first operand against a spread of second operands (R2)
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b += 29) begin
          op_check(8'(a), 8'(b), 2'(s));
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule